// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation

This block lets a CAN FD controller check its own data-phase bits when the loop through the external transceiver takes longer than one data bit. Once per frame it measures, in minimum time quanta (mtq), how long a falling edge on the transmit line takes to come back on the receive line. It adds a configured offset to that delay and saturates the result. The sum is the compensation value: the distance from the start of each transmitted data bit to the point where that bit is checked on the receive line. This checking point is the secondary sample point.

The transmitted value of every data-phase bit is stored with a timestamp in a short history. When a stored bit has aged by exactly the compensation value, the receive line is compared with it. A mismatch is not reported at once. It is held and signalled at the next regular sample point. Checking applies only when compensation is enabled and the bus is in the data phase. It ends at the sample point of the CRC delimiter. A frame start or an init discards everything still outstanding.

All timing advances on a one-clock mtq enable (`tick`). Every strobe input is honoured only on a clock where `tick` is high.

Top module: `can_fd_txdelay_comp`

## Requirements
- R1: On the tick where `meas_start` is high, a counter starts at zero. On each later tick the counter increments. The measured delay is the counter value on the first later tick where `rx_bit` is low after being high on the previous tick. If no such tick occurs, the measured delay saturates at 127.
- R2: One clock after a measurement completes, with `comp_en` high, `comp_value` becomes min(measured delay + `comp_offset`, 127). When `comp_en` is low, `comp_value` keeps its previous value.
- R3: `init` clears `comp_value` to 0 in the next clock. It also discards every outstanding bit, any pending error and any running measurement.
- R4: On each tick with `data_bit_start` high while checking is on, the current `tx_bit` is stored with its start time. On the tick that lies exactly `comp_value` ticks after that start, `rx_bit` is compared with the stored value. No comparison happens while `comp_value` is 0.
- R5: A mismatch raises `bit_err` for exactly one clock. That clock follows the first tick carrying `sample_pt` that comes strictly after the tick of the mismatch.
- R6: Checking is on only while `comp_en` is high, `data_phase` is high and `arb_phase` is low. A corrupted receive line during arbitration, or in a frame with compensation disabled, never raises `bit_err`.
- R7: A tick with `crc_delim_sp` high stops checking until the next frame start and discards stored bits not yet compared. No comparison happens on that tick. An error already pending is still reported at a sample point.
- R8: A tick with `frame_start` high discards a pending error and all stored bits.
- R9: Up to 6 stored bits can be outstanding at once. With a compensation value close to six data-bit times, each of them is still compared at its own secondary sample point.
- R10: Strobes are ignored on clocks where `tick` is low. The measured delay is counted in ticks, not clocks.
- R11: After reset, `comp_value` is 0 and `bit_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | mtq enable, one clock wide |
| init | input | 1 | Controller initialisation request |
| comp_en | input | 1 | Compensation enable |
| comp_offset | input | 7 | Offset added to the measured delay, in mtq |
| tx_bit | input | 1 | Transmit bit stream |
| rx_bit | input | 1 | Receive bit stream |
| arb_phase | input | 1 | Arbitration phase indication |
| data_phase | input | 1 | Data phase indication |
| frame_start | input | 1 | Start-of-frame strobe |
| meas_start | input | 1 | Strobe on the tick of the transmit falling edge that starts the measurement |
| data_bit_start | input | 1 | Strobe on the first tick of each transmitted data-phase bit |
| sample_pt | input | 1 | Regular sample point strobe |
| crc_delim_sp | input | 1 | Sample point strobe of the CRC delimiter |
| comp_value | output | 7 | Current compensation value, in mtq |
| bit_err | output | 1 | One-clock bit error pulse |

## Verification
A wrong measurement count or a wrong saturation shows up on `comp_value` one clock after the measurement ends. That is well before the data phase in which the value is used. A wrong history pointer, timestamp or compare point shows up as a `bit_err` pulse that is missing, extra or on the wrong sample point. The earliest such pulse comes at the regular sample point after the affected secondary sample point, so a fault is visible within one data bit of that point. A flush or stop that fails to clear state shows up as an error reported after a CRC delimiter or a frame start that should have suppressed it.

// File: rtl/fdtdc_pkg.sv
// Package: shared constants and the history entry type for the
// transmitter delay compensation block.
package fdtdc_pkg;
    localparam int COMP_W     = 7;    // width of the compensation value
    localparam int COMP_MAX   = 127;  // saturation limit in mtq
    localparam int HIST_DEPTH = 6;    // outstanding data bits held
    localparam int STAMP_W    = 10;   // width of the mtq timestamp

    // one stored transmitted bit with the tick at which it started
    typedef struct packed {
        logic               tx_val;
        logic [STAMP_W-1:0] stamp;
    } hist_ent_t;
endpackage

// File: rtl/fdtdc_loop_meter.sv
// Module: fdtdc_loop_meter
// Counts ticks from a start strobe until the first falling edge on the
// receive line, and reports the count with a one-clock done pulse.
// Assumes: start is given on the tick where tx falls, and rx is high
// before the edge comes back. The count saturates at MAXV.
module fdtdc_loop_meter #(
    parameter int CW   = 7,
    parameter int MAXV = 127
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          init,
    input  logic          start,
    input  logic          rx_bit,
    output logic          done,
    output logic [CW-1:0] delay
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          rx_prev_q;
    logic          done_q;
    logic [CW-1:0] delay_q;
    logic [CW-1:0] cnt_inc;
    logic          rx_fall;

    // next count and receive falling-edge detection
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        rx_fall = rx_prev_q & ~rx_bit;
    end

    // measurement state machine: idle, counting, finished
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            rx_prev_q <= 1'b1;
            done_q    <= 1'b0;
            delay_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                rx_prev_q <= rx_bit;
                if (start) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                end else if (busy_q) begin
                    cnt_q <= cnt_inc;
                    if (rx_fall || cnt_inc == CW'(MAXV)) begin
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        delay_q <= cnt_inc;
                    end
                end
            end
        end
    end

    assign done  = done_q;
    assign delay = delay_q;

    // R1: a running count never reaches the saturation limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CW'(MAXV)));
endmodule

// File: rtl/fdtdc_tx_history.sv
// Module: fdtdc_tx_history
// Circular store of transmitted data bits with their start timestamps.
// It holds DEPTH entries and gives the oldest one at its head.
// Assumes: the caller never pushes while the store is full. Flush has
// priority over push and pop.
module fdtdc_tx_history
    import fdtdc_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int SW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          push_bit,
    input  logic [SW-1:0] push_stamp,
    input  logic          pop,
    output logic          head_bit,
    output logic [SW-1:0] head_stamp,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [PW-1:0] wr_q, rd_q;
    logic [NW-1:0] cnt_q;
    logic          mem_bit   [DEPTH];
    logic [SW-1:0] mem_stamp [DEPTH];
    logic          do_push, do_pop;

    // qualify push and pop against the fill level
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == NW'(DEPTH));
        do_push = push & ~full & ~flush;
        do_pop  = pop & ~empty & ~flush;
    end

    // one storage slot per entry, written when the write pointer selects it
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_bit[gi]   <= 1'b0;
                mem_stamp[gi] <= '0;
            end else if (do_push && wr_q == PW'(gi)) begin
                mem_bit[gi]   <= push_bit;
                mem_stamp[gi] <= push_stamp;
            end
        end
    end

    // pointer and fill-level bookkeeping with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + NW'(do_push) - NW'(do_pop);
        end
    end

    assign head_bit   = mem_bit[rd_q];
    assign head_stamp = mem_stamp[rd_q];

    // R9: a push never meets a full store without a pop
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));
    // R7: a flush leaves the store empty
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/fdtdc_ssp_check.sv
// Module: fdtdc_ssp_check
// Secondary sample point comparison. It pops the oldest stored bit once
// that bit has aged by the compensation value and compares it with the
// receive line. A mismatch is held and reported at the next regular
// sample point.
// Assumes: SW > CW, and entries are stored in start order.
module fdtdc_ssp_check #(
    parameter int CW = 7,
    parameter int SW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          init,
    input  logic          frame_start,
    input  logic          chk_on,
    input  logic [CW-1:0] comp_value,
    input  logic [SW-1:0] now,
    input  logic          head_bit,
    input  logic [SW-1:0] head_stamp,
    input  logic          empty,
    input  logic          rx_bit,
    input  logic          sample_pt,
    output logic          pop,
    output logic          bit_err
);
    logic [SW-1:0] elapsed;
    logic          hit, mismatch, report;
    logic          pend_q, err_q;

    // decide whether this tick is the secondary sample point of the head
    always_comb begin
        elapsed  = now - head_stamp;
        hit      = tick & chk_on & ~empty & (comp_value != '0)
                 & (elapsed == {{(SW-CW){1'b0}}, comp_value});
        mismatch = hit & (rx_bit != head_bit);
        report   = tick & sample_pt & pend_q;
    end

    // pending error register: frame start clears, mismatch sets, report clears
    always_ff @(posedge clk) begin
        if (!rst_n || init || (tick && frame_start)) begin
            pend_q <= 1'b0;
        end else if (mismatch) begin
            pend_q <= 1'b1;
        end else if (report) begin
            pend_q <= 1'b0;
        end
    end

    // one-clock error pulse after the reporting sample point
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= report & ~init & ~frame_start;
    end

    assign pop     = hit;
    assign bit_err = err_q;

    // R5: an error pulse only follows a ticked regular sample point
    a_r5_err_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(tick && sample_pt));
endmodule

// File: rtl/can_fd_txdelay_comp.sv
// Module: can_fd_txdelay_comp
// Top of the transmitter delay compensation. It joins the loop delay
// meter, the transmitted-bit history and the secondary sample point
// checker, and keeps the mtq time base and the compensation value.
// Assumes: strobes are one tick wide, and delay plus offset stays below
// HIST_DEPTH data-bit times.
module can_fd_txdelay_comp
    import fdtdc_pkg::*;
#(
    parameter int CW    = COMP_W,
    parameter int MAXV  = COMP_MAX,
    parameter int DEPTH = HIST_DEPTH,
    parameter int SW    = STAMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          init,
    input  logic          comp_en,
    input  logic [CW-1:0] comp_offset,
    input  logic          tx_bit,
    input  logic          rx_bit,
    input  logic          arb_phase,
    input  logic          data_phase,
    input  logic          frame_start,
    input  logic          meas_start,
    input  logic          data_bit_start,
    input  logic          sample_pt,
    input  logic          crc_delim_sp,
    output logic [CW-1:0] comp_value,
    output logic          bit_err
);
    localparam int SUMW = CW + 1;

    logic [SW-1:0]   now_q;
    logic            stopped_q;
    logic [CW-1:0]   comp_q;
    logic            meas_done;
    logic [CW-1:0]   meas_delay;
    logic [SUMW-1:0] sum_w;
    logic [CW-1:0]   sum_sat;
    logic            chk_on, push, flush, pop;
    logic            head_bit, empty, full;
    logic [SW-1:0]   head_stamp;

    // checking window, history control and saturated sum
    always_comb begin
        chk_on  = comp_en & data_phase & ~arb_phase & ~stopped_q & ~crc_delim_sp;
        push    = tick & data_bit_start & chk_on;
        flush   = init | (tick & (crc_delim_sp | frame_start));
        sum_w   = {1'b0, meas_delay} + {1'b0, comp_offset};
        sum_sat = (sum_w > SUMW'(MAXV)) ? CW'(MAXV) : sum_w[CW-1:0];
    end

    // free-running mtq time base used for timestamps
    always_ff @(posedge clk) begin
        if (!rst_n)    now_q <= '0;
        else if (tick) now_q <= now_q + 1'b1;
    end

    // stop flag: set at the CRC delimiter sample point, cleared by frame start
    always_ff @(posedge clk) begin
        if (!rst_n || init)               stopped_q <= 1'b0;
        else if (tick && frame_start)     stopped_q <= 1'b0;
        else if (tick && crc_delim_sp)    stopped_q <= 1'b1;
    end

    // compensation value: cleared by init, loaded after each measurement
    always_ff @(posedge clk) begin
        if (!rst_n || init)             comp_q <= '0;
        else if (meas_done && comp_en)  comp_q <= sum_sat;
    end

    fdtdc_loop_meter #(.CW(CW), .MAXV(MAXV)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .init   (init),
        .start  (meas_start),
        .rx_bit (rx_bit),
        .done   (meas_done),
        .delay  (meas_delay)
    );

    fdtdc_tx_history #(.DEPTH(DEPTH), .SW(SW)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (push),
        .push_bit   (tx_bit),
        .push_stamp (now_q),
        .pop        (pop),
        .head_bit   (head_bit),
        .head_stamp (head_stamp),
        .empty      (empty),
        .full       (full)
    );

    fdtdc_ssp_check #(.CW(CW), .SW(SW)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .init        (init),
        .frame_start (frame_start),
        .chk_on      (chk_on),
        .comp_value  (comp_q),
        .now         (now_q),
        .head_bit    (head_bit),
        .head_stamp  (head_stamp),
        .empty       (empty),
        .rx_bit      (rx_bit),
        .sample_pt   (sample_pt),
        .pop         (pop),
        .bit_err     (bit_err)
    );

    assign comp_value = comp_q;

    // R2: without an enabled measurement result or init, the value holds
    a_r2_comp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(meas_done && comp_en) && !init) |=> $stable(comp_value));
    // R3: init clears the compensation value in the next clock
    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (comp_value == '0));
endmodule

// File: tb/can_fd_txdelay_comp_test.sv
`timescale 1ns/1ps
module can_fd_txdelay_comp_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, init = 1'b0, comp_en = 1'b0;
    logic [6:0] comp_offset = '0;
    logic       tx_bit = 1'b1, rx_bit = 1'b1;
    logic       arb_phase = 1'b1, data_phase = 1'b0, frame_start = 1'b0;
    logic       meas_start = 1'b0, data_bit_start = 1'b0, sample_pt = 1'b0;
    logic       crc_delim_sp = 1'b0;
    logic [6:0] comp_value;
    logic       bit_err;

    int checks = 0;
    int errors = 0;
    int exp_comp = 0;
    bit done_flag = 0;
    localparam logic [11:0] PAT = 12'b1011_0010_1101;

    always #4 clk = ~clk;

    can_fd_txdelay_comp uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .init(init), .comp_en(comp_en),
        .comp_offset(comp_offset), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .arb_phase(arb_phase), .data_phase(data_phase), .frame_start(frame_start),
        .meas_start(meas_start), .data_bit_start(data_bit_start),
        .sample_pt(sample_pt), .crc_delim_sp(crc_delim_sp),
        .comp_value(comp_value), .bit_err(bit_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one frame: arbitration with measurement, data bits, CRC delimiter, tail
    task automatic run_frame(input int d, input int off, input bit en, input int flip,
                             input int stop, input int gap, input bit arb_bad,
                             input string req);
        logic txa [0:511];
        int c, tend, meas, err_t, ssp, bad, first_t;
        logic first_a;
        c    = 150 + 10 * stop + 7;
        tend = c + 40;
        meas = (d >= 1 && d <= 127) ? d : 127;
        if (en) exp_comp = (meas + off > 127) ? 127 : meas + off;
        err_t = -1;
        if (en && flip >= 0 && flip <= stop && exp_comp != 0) begin
            ssp = 150 + 10 * flip + exp_comp;
            if (ssp < c)
                for (int s = 7; s <= tend; s += 10)
                    if (s > ssp && err_t < 0) err_t = s;
        end
        for (int t = 0; t < 512; t++) begin
            if (t < 4)                          txa[t] = 1'b1;
            else if (t < 150)                   txa[t] = 1'b0;
            else if (t < 150 + 10 * stop)       txa[t] = PAT[((t - 150) / 10) % 12];
            else                                txa[t] = 1'b1;
        end
        bad = 0; first_t = -1; first_a = 1'b0;
        comp_en = en; comp_offset = 7'(off);
        for (int t = 0; t <= tend; t++) begin
            tx_bit = txa[t];
            rx_bit = (t >= d) ? txa[t - d] : 1'b1;
            if (flip >= 0 && t >= 150 + 10 * flip + d && t < 160 + 10 * flip + d)
                rx_bit = ~rx_bit;
            if (arb_bad && (t == 1 || t == 2)) rx_bit = 1'b0;
            frame_start    = (t == 0);
            arb_phase      = (t < 150);
            data_phase     = (t >= 150 && t <= c);
            meas_start     = (t == 4);
            data_bit_start = (t >= 150 && t <= 150 + 10 * stop && (t - 150) % 10 == 0);
            sample_pt      = (t % 10 == 7);
            crc_delim_sp   = (t == c);
            for (int g = 0; g <= gap; g++) begin
                tick = (g == 0);
                @(posedge clk); #1;
                if (bit_err !== ((g == 0) && (t == err_t))) begin
                    bad++;
                    if (first_t < 0) begin first_t = t; first_a = bit_err; end
                end
                if (g == 0 && t == 149)
                    check(comp_value == 7'(exp_comp), req, "comp_value",
                          comp_value, exp_comp);
                @(negedge clk);
            end
        end
        check(bad == 0, req, $sformatf("bit_err trace (first bad tick %0d, err tick %0d)",
              first_t, err_t), first_a, (first_t == err_t) ? 1 : 0);
        tick = 1'b0; frame_start = 1'b0; meas_start = 1'b0; data_bit_start = 1'b0;
        sample_pt = 1'b0; crc_delim_sp = 1'b0; data_phase = 1'b0; arb_phase = 1'b1;
        tx_bit = 1'b1; rx_bit = 1'b1;
    endtask

    // R3: init clears the compensation value
    task automatic do_init();
        init = 1'b1;
        @(posedge clk); #1;
        exp_comp = 0;
        check(comp_value == 7'd0, "R3", "comp_value after init", comp_value, 0);
        @(negedge clk);
        init = 1'b0;
    endtask

    // R8: a frame start between mismatch and sample point drops the error
    task automatic fs_clear(input bit clear_it, input string req);
        int seen;
        seen = 0;
        comp_en = 1'b1;
        for (int t = 0; t <= 24; t++) begin
            tick = 1'b1;
            frame_start    = (t == 0) || (clear_it && t == 17);
            arb_phase      = 1'b0;
            data_phase     = (t >= 1);
            data_bit_start = (t == 1);
            tx_bit         = 1'b1;
            rx_bit         = (t == 1 + exp_comp) ? 1'b0 : 1'b1;
            sample_pt      = (t == 20);
            @(posedge clk); #1;
            if (bit_err) seen++;
            if (t == 20)
                check(bit_err == !clear_it, req, "bit_err at sample point",
                      bit_err, !clear_it);
            @(negedge clk);
        end
        check(seen == (clear_it ? 0 : 1), req, "bit_err pulse count", seen,
              clear_it ? 0 : 1);
        tick = 1'b0; frame_start = 1'b0; data_bit_start = 1'b0; sample_pt = 1'b0;
        data_phase = 1'b0; arb_phase = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #0;
        // R11: reset state
        check(comp_value == 7'd0, "R11", "comp_value in reset", comp_value, 0);
        check(bit_err == 1'b0, "R11", "bit_err in reset", bit_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(10, 5, 1'b1, -1, 8, 0, 1'b0, "R1 R2");          // clean frame
        run_frame(10, 5, 1'b1, 3, 8, 0, 1'b0, "R4 R5");           // error bit 3
        run_frame(23, 8, 1'b1, 2, 8, 0, 1'b0, "R4 R5");           // other delay
        run_frame(12, 3, 1'b0, 2, 8, 0, 1'b0, "R2 R6");           // disabled: hold
        run_frame(55, 4, 1'b1, 6, 12, 0, 1'b0, "R9 R7");          // deep history
        run_frame(30, 5, 1'b1, 7, 8, 0, 1'b0, "R7");              // after CRC delim
        run_frame(10, 5, 1'b1, -1, 8, 0, 1'b1, "R6");             // arb corruption
        run_frame(10, 6, 1'b1, 1, 8, 2, 1'b0, "R10");             // gapped ticks
        run_frame(100, 27, 1'b1, -1, 0, 0, 1'b0, "R2");           // exactly 127
        run_frame(100, 40, 1'b1, -1, 0, 0, 1'b0, "R2");           // saturate sum
        run_frame(200, 3, 1'b1, -1, 0, 0, 1'b0, "R1");            // meter timeout
        do_init();
        run_frame(10, 5, 1'b1, 4, 8, 0, 1'b0, "R3 R4");           // after init
        fs_clear(1'b1, "R8");
        fs_clear(1'b0, "R5");
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule